// File: doc/BRIEF.md
# Per-Region Channel Access Mask Filter

This block sits between a simple 32-bit register bus and the 64-bit per-channel pending and interrupt-enable registers of a DMA controller. It stores a 64-bit channel access mask for each of eight software regions. An access made through a region's address window sees only the channels that the region's mask enables. Reads of disabled channel bits return zero. Writes to disabled channel bits are dropped without notice.

A separate global window bypasses every mask and is the only path that can program the masks. Channel pending bits are set by a 64-bit event input and cleared by writing ones to a clear register. Each region also gets its own registered interrupt line. That line is driven only by the channels that are pending, interrupt-enabled and enabled in that region's mask.

Top module: `region_mask_filter`

## Requirements
- R1: After reset every mask bit, pending bit and interrupt-enable bit is 0, every region interrupt is low, and read data is 0.
- R2: Address bit 11 = 0 selects the global window. Bit 11 = 1 selects a region window, and bits 10:8 give the region number. Within a window, offset 0x00/0x04 is pending low/high, 0x08/0x0C is clear low/high and 0x10/0x14 is interrupt-enable low/high. The mask of region j sits at global offset 0x40+8*j (channels 0-31) and 0x44+8*j (channels 32-63). High-word bit k is channel k+32.
- R3: Only a global-window write changes a mask. In a region window the mask offsets read 0 and writes to them have no effect.
- R4: A region-window read of pending or interrupt-enable returns 0 on each channel bit that the region's mask disables, and the true value on each enabled bit.
- R5: A region-window write to interrupt-enable updates the enabled channel bits and leaves the disabled ones unchanged.
- R6: A 1 on an event input bit sets that pending bit. Writing 1 to a clear bit clears it, but through a region window only for enabled channels. An event wins over a clear in the same cycle. Clear registers read 0.
- R7: Global-window reads and writes of pending, clear and interrupt-enable act on all 64 channels, with no masking.
- R8: Region j's interrupt is the registered OR over all channels of pending AND enable AND mask j. It changes one clock after the bits that feed it.
- R9: Read data is registered. It is valid in the cycle after the request and is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Request strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| evtIn | input | 64 | Per-channel event pulses that set pending bits |
| regionIrq | output | 8 | Registered interrupt, one bit per region |

## Verification
Register writes and event pulses take effect at the first clock edge after they are driven. Read data appears one edge after the request. A region interrupt trails the pending/enable/mask state by one more edge, so it rises two edges after an event. The bench drives on falling edges and samples on the following falling edge for read data and register effects. For interrupts it checks explicitly that the line is still low one falling edge after the event and high at the next. A clear is handled the same way: the interrupt is checked still high right after the clear write lands, and low one cycle later.

// File: rtl/region_mask_pkg.sv
package region_mask_pkg;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_PEND = 3'd1,
    SEL_CLR  = 3'd2,
    SEL_IEN  = 3'd3,
    SEL_MASK = 3'd4
  } sel_e;

  typedef struct packed {
    logic wr;
    logic rd;
    logic isGlobal;
    logic hiHalf;
    sel_e sel;
  } strobe_t;

endpackage

// File: rtl/region_mask_ctrl.sv
module region_mask_ctrl
  import region_mask_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_REGIONS = 8,
  parameter int OFS_W       = 8,
  localparam int REG_W      = $clog2(NUM_REGIONS)
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb,
  output logic [REG_W-1:0]  regionIdx,
  output logic [REG_W-1:0]  maskIdx
);

  logic [OFS_W-1:0] offset;
  logic             isGlobal;
  logic             inMaskArea;

  assign offset    = busAddr[OFS_W-1:0];
  assign isGlobal  = !busAddr[ADDR_W-1];
  assign regionIdx = busAddr[OFS_W +: REG_W];
  assign maskIdx   = offset[3 +: REG_W];

  // mask area: offsets 0x40 .. 0x40 + 8*NUM_REGIONS - 1, global window only
  assign inMaskArea = (offset[OFS_W-1:6] == 'd1) &&
                      (int'(offset[5:3]) < NUM_REGIONS);

  always_comb begin
    strb          = '0;
    strb.wr       = busValid && busWrite;
    strb.rd       = busValid && !busWrite;
    strb.isGlobal = isGlobal;
    strb.hiHalf   = offset[2];
    strb.sel      = SEL_NONE;
    if (busValid) begin
      unique case (offset[OFS_W-1:3])
        'd0:     strb.sel = SEL_PEND;
        'd1:     strb.sel = SEL_CLR;
        'd2:     strb.sel = SEL_IEN;
        default: strb.sel = (inMaskArea && isGlobal) ? SEL_MASK : SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/region_mask_dp.sv
module region_mask_dp
  import region_mask_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_REGIONS = 8,
  localparam int REG_W      = $clog2(NUM_REGIONS),
  localparam int NUM_CH     = 2 * DATA_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [REG_W-1:0]       regionIdx,
  input  logic [REG_W-1:0]       maskIdx,
  input  logic [DATA_W-1:0]      busWdata,
  input  logic [NUM_CH-1:0]      evtIn,
  output logic [DATA_W-1:0]      busRdata,
  output logic [NUM_REGIONS-1:0] regionIrq
);

  logic [NUM_REGIONS-1:0][NUM_CH-1:0] maskQ;
  logic [NUM_CH-1:0] pendQ;
  logic [NUM_CH-1:0] ienQ;
  logic [NUM_CH-1:0] effMask;
  logic [NUM_CH-1:0] halfSel;
  logic [NUM_CH-1:0] wrWide;
  logic [NUM_CH-1:0] wrBits;
  logic [NUM_CH-1:0] clrVec;
  logic [DATA_W-1:0] laneMask;
  logic [DATA_W-1:0] rdNext;
  logic              ienWr;
  logic              clrWr;
  logic              maskWr;

  function automatic logic [DATA_W-1:0] pickHalf(input logic [NUM_CH-1:0] v,
                                                 input logic hi);
    return hi ? v[NUM_CH-1:DATA_W] : v[DATA_W-1:0];
  endfunction

  assign effMask  = strb.isGlobal ? {NUM_CH{1'b1}} : maskQ[regionIdx];
  assign halfSel  = strb.hiHalf ? {{DATA_W{1'b1}}, {DATA_W{1'b0}}}
                                : {{DATA_W{1'b0}}, {DATA_W{1'b1}}};
  assign wrWide   = {busWdata, busWdata};
  assign wrBits   = halfSel & effMask;
  assign laneMask = pickHalf(effMask, strb.hiHalf);

  assign ienWr  = strb.wr && (strb.sel == SEL_IEN);
  assign clrWr  = strb.wr && (strb.sel == SEL_CLR);
  assign maskWr = strb.wr && (strb.sel == SEL_MASK);
  assign clrVec = clrWr ? (wrWide & wrBits) : '0;

  // channel state: events win over clears
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      ienQ  <= '0;
    end else begin
      pendQ <= (pendQ & ~clrVec) | evtIn;
      if (ienWr) ienQ <= (ienQ & ~wrBits) | (wrWide & wrBits);
    end
  end

  // mask registers, global window only
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (maskWr) begin
      if (strb.hiHalf) maskQ[maskIdx][NUM_CH-1:DATA_W] <= busWdata;
      else             maskQ[maskIdx][DATA_W-1:0]      <= busWdata;
    end
  end

  always_comb begin
    unique case (strb.sel)
      SEL_PEND: rdNext = pickHalf(pendQ, strb.hiHalf) & laneMask;
      SEL_IEN:  rdNext = pickHalf(ienQ, strb.hiHalf) & laneMask;
      SEL_MASK: rdNext = pickHalf(maskQ[maskIdx], strb.hiHalf);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= strb.rd ? rdNext : '0;
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gIrq
    always_ff @(posedge clk) begin
      if (!rstN) regionIrq[g] <= 1'b0;
      else       regionIrq[g] <= |(pendQ & ienQ & maskQ[g]);
    end

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rstN)
      (maskQ[g] == '0) |=> !regionIrq[g]);  // R8
  end

  AST_MASK_REGION_WR_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wr && !strb.isGlobal) |=> $stable(maskQ));  // R3

  AST_IEN_DISABLED_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (ienWr && !strb.isGlobal) |=>
      (((ienQ ^ $past(ienQ)) & ~$past(maskQ[regionIdx])) == '0));  // R5

  AST_CLR_DISABLED_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && !strb.isGlobal) |=>
      (($past(pendQ) & ~pendQ & ~$past(maskQ[regionIdx])) == '0));  // R6

  AST_EVENT_SETS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (|evtIn) |=> ((pendQ & $past(evtIn)) == $past(evtIn)));  // R6

  AST_READ_LANE_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd && !strb.isGlobal && (strb.sel inside {SEL_PEND, SEL_IEN})) |=>
      ((busRdata & ~$past(laneMask)) == '0));  // R4

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rd |=> (busRdata == '0));  // R9

endmodule

// File: rtl/region_mask_filter.sv
module region_mask_filter
  import region_mask_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int NUM_REGIONS = 8,
  localparam int REG_W      = $clog2(NUM_REGIONS),
  localparam int NUM_CH     = 2 * DATA_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busValid,
  input  logic                   busWrite,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [DATA_W-1:0]      busWdata,
  output logic [DATA_W-1:0]      busRdata,
  input  logic [NUM_CH-1:0]      evtIn,
  output logic [NUM_REGIONS-1:0] regionIrq
);

  strobe_t          strb;
  logic [REG_W-1:0] regionIdx;
  logic [REG_W-1:0] maskIdx;

  region_mask_ctrl #(
    .ADDR_W      (ADDR_W),
    .NUM_REGIONS (NUM_REGIONS)
  ) i_ctrl (
    .busValid  (busValid),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .strb      (strb),
    .regionIdx (regionIdx),
    .maskIdx   (maskIdx)
  );

  region_mask_dp #(
    .DATA_W      (DATA_W),
    .NUM_REGIONS (NUM_REGIONS)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regionIdx (regionIdx),
    .maskIdx   (maskIdx),
    .busWdata  (busWdata),
    .evtIn     (evtIn),
    .busRdata  (busRdata),
    .regionIrq (regionIrq)
  );

endmodule

// File: tb/test_region_mask_filter.sv
module test_region_mask_filter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] evtIn = '0;
  logic [7:0]  regionIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  region_mask_filter i_region_mask_filter (
    .clk       (clk),
    .rstN      (rstN),
    .busValid  (busValid),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .evtIn     (evtIn),
    .regionIrq (regionIrq)
  );

  localparam logic [11:0] R2 = 12'hA00;  // region 2 window base
  localparam logic [11:0] R0 = 12'h800;  // region 0 window base

  task automatic checkEq(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [11:0] a, logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic doRead(logic [11:0] a, output logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    d = busRdata;
    busValid = 1'b0;
  endtask

  task automatic pulseEvt(logic [63:0] v);
    evtIn = v;
    @(negedge clk);
    evtIn = '0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    checkEq("R1 irq", regionIrq, 8'h00);
    checkEq("R1 rdata", busRdata, 32'h0);
    doRead(12'h050, d); checkEq("R1 mask2 lo", d, 32'h0);
    doRead(12'h000, d); checkEq("R1 pend lo", d, 32'h0);
    doRead(12'h014, d); checkEq("R1 ien hi", d, 32'h0);
  endtask

  task automatic testMasks();
    logic [31:0] d;
    doWrite(12'h050, 32'h0000_00F0);
    doWrite(12'h054, 32'h8000_0001);
    doRead(12'h050, d); checkEq("R2 mask2 lo", d, 32'h0000_00F0);
    doRead(12'h054, d); checkEq("R2 mask2 hi", d, 32'h8000_0001);
    doRead(12'h048, d); checkEq("R2 mask1 lo untouched", d, 32'h0);
    doWrite(R2 | 12'h050, 32'hFFFF_FFFF);
    doRead(12'h050, d); checkEq("R3 region write to mask ignored", d, 32'h0000_00F0);
    doRead(R2 | 12'h050, d); checkEq("R3 region read of mask", d, 32'h0);
  endtask

  task automatic testIen();
    logic [31:0] d;
    doWrite(12'h010, 32'hFFFF_FFFF);
    doRead(12'h010, d); checkEq("R7 global ien", d, 32'hFFFF_FFFF);
    doRead(R2 | 12'h010, d); checkEq("R4 region ien read", d, 32'h0000_00F0);
    doRead(R0 | 12'h010, d); checkEq("R4 region0 ien read", d, 32'h0);
    doWrite(R2 | 12'h010, 32'h0000_0000);
    doRead(12'h010, d); checkEq("R5 region ien clear", d, 32'hFFFF_FF0F);
    doWrite(R2 | 12'h010, 32'hFFFF_FF30);
    doRead(12'h010, d); checkEq("R5 region ien set", d, 32'hFFFF_FF3F);
  endtask

  task automatic testPend();
    logic [31:0] d;
    pulseEvt(64'h0000_0000_0000_0FF0);
    doRead(12'h000, d); checkEq("R6 events set pend", d, 32'h0000_0FF0);
    checkEq("R8 irq region2 only", regionIrq, 8'h04);
    doRead(R2 | 12'h000, d); checkEq("R4 region pend read", d, 32'h0000_00F0);
    doWrite(R2 | 12'h008, 32'hFFFF_FFFF);
    @(negedge clk);
    checkEq("R8 irq drops after clear", regionIrq, 8'h00);
    doRead(12'h000, d); checkEq("R6 region clear masked", d, 32'h0000_0F00);
    doRead(12'h008, d); checkEq("R6 clear reads zero", d, 32'h0);
    // event and clear on the same channel in one cycle
    busValid = 1'b1; busWrite = 1'b1; busAddr = 12'h008; busWdata = 32'h0000_0200;
    evtIn = 64'h200;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; evtIn = '0;
    doRead(12'h000, d); checkEq("R6 event wins over clear", d, 32'h0000_0F00);
    doWrite(12'h008, 32'h0000_0F00);
    doRead(12'h000, d); checkEq("R7 global clear", d, 32'h0);
  endtask

  task automatic testIrq();
    logic [31:0] d;
    doWrite(12'h014, 32'h8000_0000);
    pulseEvt({32'h8000_0003, 32'h0});
    checkEq("R8 irq not yet", regionIrq, 8'h00);
    @(negedge clk);
    checkEq("R8 irq one cycle later", regionIrq, 8'h04);
    doRead(R2 | 12'h004, d); checkEq("R2 high word mapping", d, 32'h8000_0001);
    doRead(12'h004, d); checkEq("R7 global pend hi", d, 32'h8000_0003);
    doWrite(R2 | 12'h00C, 32'hFFFF_FFFF);
    checkEq("R8 irq held until next edge", regionIrq, 8'h04);
    @(negedge clk);
    checkEq("R8 irq falls", regionIrq, 8'h00);
    doRead(12'h004, d); checkEq("R6 region clear hi masked", d, 32'h0000_0002);
  endtask

  task automatic testRdTiming();
    logic [31:0] d;
    doRead(12'h054, d); checkEq("R9 data next cycle", d, 32'h8000_0001);
    @(negedge clk);
    checkEq("R9 idle rdata zero", busRdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMasks();
    testIen();
    testPend();
    testIrq();
    testRdTiming();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(negedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule